// File: doc/BRIEF.md
# Approximate Signed-Digit Multiply-Accumulate Unit

This block is a clocked multiply-accumulate engine for unsigned N-bit operands. Each strobed operation adds the product of two operands to a 2N-bit accumulator, and the sum wraps modulo 2^(2N). Inside the block, every addition pairs one plain binary operand with one signed-digit operand. Each digit of the signed-digit operand is held as a plus bit and a minus bit, and its value is plus minus minus. This means no carry travels more than one position in any adder row. The partial products are summed row by row into a signed-digit running sum. One further row adds the binary accumulator to that sum. A single subtraction of the minus vector from the plus vector then returns the result to binary, and the result is written back to the accumulator.

Parameter K sets how many of the most significant digit positions use the exact adder cell. The remaining low positions use a cheaper cell whose outgoing carry is simply the incoming plus bit. With K = 2N the unit is exact. Smaller K trades accuracy in the low bits for shorter logic.

The unit has a one-cycle operand capture stage and a one-cycle compute-and-store stage. It accepts a new operation on every clock cycle. A synchronous clear empties the accumulator.

Top module: `hr_approx_mac`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the accumulator reads zero and `out_valid` is low.
- R2: Operands are captured at the clock edge where `in_valid` is high. The accumulator takes the new value at the following edge, and `out_valid` is high for exactly that one cycle.
- R3: With K = 2N, every operation sets the accumulator to (old + b·c) mod 2^(2N), exactly.
- R4: With `in_valid` high on consecutive cycles, every operation is accumulated, one per cycle, with none lost or repeated.
- R5: `clear` acts at the clock edge. It sets the accumulator to zero, and an update due at that same edge is discarded with `out_valid` low. An operation captured at that same edge is kept and is added to zero at the next edge.
- R6: In a cycle with no captured operation and no clear, the accumulator keeps its value and `out_valid` stays low.
- R7: `acc_hi` carries accumulator bits 2N-1..N and `acc_lo` carries bits N-1..0.
- R8: Cell rule. The cell at position i takes digit value v = p - m + y and outputs the minus bit m_out[i] = 1 when v is odd. The exact cell outputs the carry plus bit p_out[i+1] = 1 when v ≥ 1. The approximate cell, used at positions i < 2N-K, outputs p_out[i+1] = p. The value p_out[0] is 0, and the carry out of position 2N-1 is dropped. Rows are added in this order: partial product j = 0 up to N-1 (each being c shifted left by j when bit j of b is 1, else zero), starting from an all-zero sum, then the accumulator. The binary result is plus vector minus minus vector, taken mod 2^(2N).
- R9: For any K, the result of one operation differs from (old + b·c) mod 2^(2N) by at most (N+1)·(2^(2N-K+1) - 2).
- R10: Sums past 2^(2N) - 1 wrap. With N = 16, adding 0xFFFF·0xFFFF twice from zero gives 0xFFFC0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous accumulator clear |
| in_valid | input | 1 | Operand strobe |
| b_in | input | N | Multiplier operand |
| c_in | input | N | Multiplicand operand |
| acc_hi | output | N | Upper half of accumulator |
| acc_lo | output | N | Lower half of accumulator |
| out_valid | output | 1 | Accumulator updated this cycle |

## Verification
An exact instance and an approximate instance (K = N) receive the same stimulus. The exact instance is compared against plain integer arithmetic. The approximate instance is compared against a digit-by-digit model of the cell rule and is also held to the error bound.

The all-zero, all-one, alternating and walking-one operands each stress a different case. Zero rows leave the sum untouched. Dense ones drive every cell through its carry cases, so they expose a wrong carry term. Alternating bits separate exact positions from approximate ones. A walking one exposes a misplaced partial-product shift.

Back-to-back bursts, idle gaps and clear at each pipeline stage separate capture timing from update timing. Two maximal products show the wrap.

// File: rtl/hr_mac_pkg.sv
package hr_mac_pkg;

    // Outgoing plus bit of the exact cell: digit value p - m + y is at least one.
    function automatic logic hr_plus_exact(input logic p, input logic m, input logic y);
        return (p & ~m) | (p & y) | (~m & y);
    endfunction

    // Minus bit of either cell: digit value is odd.
    function automatic logic hr_minus(input logic p, input logic m, input logic y);
        return p ^ m ^ y;
    endfunction

    // Number of low positions built from the approximate cell.
    function automatic int hr_approx_count(input int width, input int exact_msbs);
        if (exact_msbs >= width) return 0;
        if (exact_msbs <= 0)     return width;
        return width - exact_msbs;
    endfunction

endpackage

// File: rtl/hr_add_row.sv
// One row of signed-digit plus binary adder cells, carry-free.
module hr_add_row
    import hr_mac_pkg::*;
#(
    parameter int W       = 32,
    parameter int NAPPROX = 0
) (
    input  logic [W-1:0] xp,
    input  logic [W-1:0] xm,
    input  logic [W-1:0] y,
    output logic [W-1:0] sp,
    output logic [W-1:0] sm
);

    logic [W-1:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_cell
        assign sm[i] = hr_minus(xp[i], xm[i], y[i]);
        if (i < W - 1) begin : g_carry
            if (i < NAPPROX) begin : g_apx
                assign carry[i+1] = xp[i];
            end else begin : g_exa
                assign carry[i+1] = hr_plus_exact(xp[i], xm[i], y[i]);
            end
        end
    end

    assign sp = carry;

endmodule

// File: rtl/hr_mult_array.sv
// Array multiplier: binary partial products summed into a signed-digit sum.
module hr_mult_array #(
    parameter int N       = 16,
    parameter int NAPPROX = 0,
    localparam int P      = 2 * N
) (
    input  logic [N-1:0] b,
    input  logic [N-1:0] c,
    output logic [P-1:0] prod_p,
    output logic [P-1:0] prod_m
);

    logic [P-1:0] c_ext;
    logic [P-1:0] pp   [N];
    logic [P-1:0] run_p[N+1];
    logic [P-1:0] run_m[N+1];

    assign c_ext    = {{N{1'b0}}, c};
    assign run_p[0] = '0;
    assign run_m[0] = '0;

    for (genvar j = 0; j < N; j++) begin : g_row
        assign pp[j] = b[j] ? (c_ext << j) : '0;

        hr_add_row #(
            .W       (P),
            .NAPPROX (NAPPROX)
        ) u_row (
            .xp (run_p[j]),
            .xm (run_m[j]),
            .y  (pp[j]),
            .sp (run_p[j+1]),
            .sm (run_m[j+1])
        );
    end

    assign prod_p = run_p[N];
    assign prod_m = run_m[N];

endmodule

// File: rtl/hr_to_bin.sv
// Signed-digit to binary: plus vector minus minus vector.
module hr_to_bin #(
    parameter int W = 32
) (
    input  logic [W-1:0] vp,
    input  logic [W-1:0] vm,
    output logic [W-1:0] bin
);

    assign bin = vp - vm;

endmodule

// File: rtl/hr_approx_mac.sv
module hr_approx_mac
    import hr_mac_pkg::*;
#(
    parameter int N = 16,
    parameter int K = N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         in_valid,
    input  logic [N-1:0] b_in,
    input  logic [N-1:0] c_in,
    output logic [N-1:0] acc_hi,
    output logic [N-1:0] acc_lo,
    output logic         out_valid
);

    localparam int P       = 2 * N;
    localparam int NAPPROX = hr_approx_count(P, K);

    typedef struct packed {
        logic         load;
        logic [N-1:0] b;
        logic [N-1:0] c;
        logic [P-1:0] acc;
        logic         done;
    } mac_st_t;

    mac_st_t st_d, st_q;

    logic [P-1:0] prod_p, prod_m;
    logic [P-1:0] sum_p, sum_m;
    logic [P-1:0] acc_next;

    // Stage signals exposed for the bound checker.
    logic         ld_q;
    logic [N-1:0] b_q, c_q;

    assign ld_q = st_q.load;
    assign b_q  = st_q.b;
    assign c_q  = st_q.c;

    hr_mult_array #(
        .N       (N),
        .NAPPROX (NAPPROX)
    ) u_mult (
        .b      (st_q.b),
        .c      (st_q.c),
        .prod_p (prod_p),
        .prod_m (prod_m)
    );

    hr_add_row #(
        .W       (P),
        .NAPPROX (NAPPROX)
    ) u_acc_row (
        .xp (prod_p),
        .xm (prod_m),
        .y  (st_q.acc),
        .sp (sum_p),
        .sm (sum_m)
    );

    hr_to_bin #(
        .W (P)
    ) u_conv (
        .vp  (sum_p),
        .vm  (sum_m),
        .bin (acc_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.load = in_valid;
        st_d.done = 1'b0;
        if (in_valid) begin
            st_d.b = b_in;
            st_d.c = c_in;
        end
        if (clear) begin
            st_d.acc = '0;
        end else if (st_q.load) begin
            st_d.acc  = acc_next;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_hi    = st_q.acc[P-1:N];
    assign acc_lo    = st_q.acc[N-1:0];
    assign out_valid = st_q.done;

endmodule

// File: rtl/hr_approx_mac_chk.sv
module hr_approx_mac_chk #(
    parameter int N = 16,
    parameter int K = N
) (
    input logic           clk,
    input logic           rst_n,
    input logic           clear,
    input logic           in_valid,
    input logic           ld_q,
    input logic [N-1:0]   b_q,
    input logic [N-1:0]   c_q,
    input logic [2*N-1:0] acc,
    input logic           out_valid
);

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ld_q);  // R2

    AST_UPDATE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_q && !clear) |=> out_valid);  // R2

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(ld_q) && !$past(clear)));  // R2

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc == '0 && !out_valid));  // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_q && !clear) |=> ($stable(acc) && !out_valid));  // R6

    if (K >= 2 * N) begin : g_exact
        logic [2*N-1:0] acc_want;
        assign acc_want = acc + ({{N{1'b0}}, b_q} * {{N{1'b0}}, c_q});

        AST_EXACT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_q && !clear) |=> (acc == $past(acc_want)));  // R3
    end

endmodule

bind hr_approx_mac hr_approx_mac_chk #(
    .N (N),
    .K (K)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .in_valid  (in_valid),
    .ld_q      (ld_q),
    .b_q       (b_q),
    .c_q       (c_q),
    .acc       ({acc_hi, acc_lo}),
    .out_valid (out_valid)
);

// File: tb/sim_hr_approx_mac.sv
module sim_hr_approx_mac;

    localparam int N     = 16;
    localparam int P     = 2 * N;
    localparam int KA    = N;
    localparam int NAPX  = P - KA;
    localparam int BOUND = (N + 1) * ((1 << (P - KA + 1)) - 2);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clear = 1'b0;
    logic         in_valid = 1'b0;
    logic [N-1:0] b_in = '0;
    logic [N-1:0] c_in = '0;

    logic [N-1:0] hi0, lo0, hi1, lo1;
    logic         ov0, ov1;

    int n_chk  = 0;
    int n_fail = 0;

    logic [P-1:0] exp_ex = '0;
    logic [P-1:0] exp_ax = '0;

    always #5 clk = ~clk;

    hr_approx_mac #(.N(N), .K(P)) u0 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
        .b_in(b_in), .c_in(c_in), .acc_hi(hi0), .acc_lo(lo0), .out_valid(ov0)
    );

    hr_approx_mac #(.N(N), .K(KA)) u1 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
        .b_in(b_in), .c_in(c_in), .acc_hi(hi1), .acc_lo(lo1), .out_valid(ov1)
    );

    // Digit-level model of one adder row, written from the cell rule.
    function automatic void mrow(inout logic [P-1:0] p, inout logic [P-1:0] m,
                                 input logic [P-1:0] y, input int napp);
        logic [P-1:0] np, nm;
        np = '0;
        nm = '0;
        for (int i = 0; i < P; i++) begin
            int v;
            v = int'(p[i]) - int'(m[i]) + int'(y[i]);
            nm[i] = (v == 1) || (v == -1);
            if (i < P - 1) np[i+1] = (i < napp) ? p[i] : (v >= 1);
        end
        p = np;
        m = nm;
    endfunction

    function automatic logic [P-1:0] mmac(input logic [P-1:0] acc, input logic [N-1:0] b,
                                          input logic [N-1:0] c, input int napp);
        logic [P-1:0] p, m, y;
        p = '0;
        m = '0;
        for (int j = 0; j < N; j++) begin
            y = b[j] ? (P'(c) << j) : '0;
            mrow(p, m, y, napp);
        end
        mrow(p, m, acc, napp);
        return p - m;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [P-1:0] act,
                       input logic [P-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag, input bit ov);
        chk({hi0, lo0} == exp_ex, {tag, " exact acc"}, {hi0, lo0}, exp_ex);
        chk({hi1, lo1} == exp_ax, {tag, " approx acc"}, {hi1, lo1}, exp_ax);
        chk(ov0 == ov && ov1 == ov, {tag, " out_valid"}, P'({ov0, ov1}), P'({ov, ov}));
    endtask

    // Apply model update for one operation and check the bound.
    task automatic retire(input string tag, input logic [N-1:0] b, input logic [N-1:0] c);
        logic [P-1:0] ideal, err;
        int           e;
        ideal  = exp_ax + P'(b) * P'(c);
        exp_ex = exp_ex + P'(b) * P'(c);
        exp_ax = mmac(exp_ax, b, c, NAPX);
        chk_state(tag, 1'b1);
        err = {hi1, lo1} - ideal;
        e   = int'($signed(err));
        chk(e <= BOUND && e >= -BOUND, {tag, " R9 error bound"}, err, P'(BOUND));
    endtask

    task automatic single_op(input string tag, input logic [N-1:0] b, input logic [N-1:0] c);
        in_valid = 1'b1;
        b_in     = b;
        c_in     = c;
        @(negedge clk);
        in_valid = 1'b0;
        chk(ov0 == 1'b0, {tag, " R2 no early update"}, P'(ov0), '0);
        @(negedge clk);
        retire({tag, " R2 R3 R8"}, b, c);
        chk(hi0 == exp_ex[P-1:N] && lo0 == exp_ex[N-1:0], {tag, " R7 halves"},
            {hi0, lo0}, exp_ex);
        @(negedge clk);
        chk_state({tag, " R2 single pulse"}, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_state("R1 in reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R1 after reset", 1'b0);
    endtask

    task automatic t_patterns();
        single_op("zeros", 16'h0000, 16'h0000);
        single_op("ones", 16'hFFFF, 16'hFFFF);
        single_op("alt", 16'hAAAA, 16'h5555);
        for (int s = 0; s < N; s += 5) begin
            single_op("walk", N'(1) << s, 16'hB3C5);
        end
    endtask

    task automatic t_burst(input int len);
        logic [N-1:0] bb[16];
        logic [N-1:0] cc[16];
        for (int i = 0; i < len; i++) begin
            bb[i] = N'($urandom);
            cc[i] = N'($urandom);
        end
        for (int i = 0; i <= len; i++) begin
            if (i < len) begin
                in_valid = 1'b1;
                b_in     = bb[i];
                c_in     = cc[i];
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
            if (i >= 1) retire("R4 burst", bb[i-1], cc[i-1]);
        end
        @(negedge clk);
        chk_state("R4 burst end", 1'b0);
    endtask

    task automatic t_idle();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk_state("R6 idle hold", 1'b0);
        end
    endtask

    task automatic t_clear();
        clear = 1'b1;
        @(negedge clk);
        clear  = 1'b0;
        exp_ex = '0;
        exp_ax = '0;
        chk_state("R5 plain clear", 1'b0);

        single_op("R5 preload", 16'h1234, 16'h0F0F);
        in_valid = 1'b1;
        b_in     = 16'h7777;
        c_in     = 16'h0333;
        @(negedge clk);
        in_valid = 1'b0;
        clear    = 1'b1;
        @(negedge clk);
        clear  = 1'b0;
        exp_ex = '0;
        exp_ax = '0;
        chk_state("R5 update dropped", 1'b0);
        @(negedge clk);
        chk_state("R5 dropped stays gone", 1'b0);

        single_op("R5 preload2", 16'h0101, 16'hFEDC);
        clear    = 1'b1;
        in_valid = 1'b1;
        b_in     = 16'h00FF;
        c_in     = 16'h8001;
        @(negedge clk);
        clear    = 1'b0;
        in_valid = 1'b0;
        exp_ex   = '0;
        exp_ax   = '0;
        chk_state("R5 clear with capture", 1'b0);
        @(negedge clk);
        retire("R5 captured op added to zero", 16'h00FF, 16'h8001);
        @(negedge clk);
    endtask

    task automatic t_wrap();
        clear = 1'b1;
        @(negedge clk);
        clear  = 1'b0;
        exp_ex = '0;
        exp_ax = '0;
        single_op("R10 first", 16'hFFFF, 16'hFFFF);
        single_op("R10 second", 16'hFFFF, 16'hFFFF);
        chk({hi0, lo0} == 32'hFFFC0002, "R10 wrap literal", {hi0, lo0}, 32'hFFFC0002);
    endtask

    initial begin
        #(10 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_patterns();
        t_burst(8);
        t_idle();
        t_clear();
        t_wrap();
        for (int r = 0; r < 20; r++) t_burst(16);
        t_idle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule